// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation table held in ordinary memory. A requester presents the virtual address together with the kind of access (read, write or instruction fetch). The walker reads one directory word, then one leaf word, through a single-outstanding word port. It answers with the physical address and the leaf's permission bits, or with a fault code. When the access is allowed, the walker also records use of the page in the leaf word, and it writes the word back only when a bit actually changes.

The root of the walk is a page frame number supplied on an input. It is sampled when a request is accepted, so switching it to a different table takes effect for the next translation. The address splits into a 10-bit directory index (bits 31:22), a 10-bit table index (bits 21:12) and a 12-bit byte offset, which gives 4 KiB pages. Each table word is 4 bytes.

The controller is a five-state machine. `ST_IDLE` waits for a request and moves to `ST_READ_DIR` on acceptance. `ST_READ_DIR` fetches the directory word and moves to `ST_READ_PTE` if the word is present, or to `ST_DONE` with a fault if it is not. `ST_READ_PTE` fetches the leaf word and then moves to one of two states. It goes to `ST_UPDATE_PTE` if the access is allowed and the use bits must change. Otherwise it goes to `ST_DONE`, carrying either a result or a fault. `ST_UPDATE_PTE` writes the leaf back and moves to `ST_DONE` when memory acknowledges. `ST_DONE` holds the answer until the requester takes it, then returns to `ST_IDLE`.

Top module: `pgwalk_top`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: Table word layout: bit 0 present, bit 1 dirty, bit 2 referenced, bit 3 read-allowed, bit 4 write-allowed, bit 5 execute-allowed, bits 31:12 frame number. The first read goes to `{root_frame, 12'h0} + 4*va[31:22]`. The second read goes to `{dir[31:12], 12'h0} + 4*va[21:12]`.
- R3: A directory word with bit 0 clear ends the walk with fault code 1. No leaf read and no write take place.
- R4: A leaf word with bit 0 clear ends the walk with fault code 2, and no write takes place.
- R5: Access kind encoding is 0 read, 1 write and 2 execute; code 3 is never allowed. The access needs leaf bit 3, 4 or 5 respectively. If that bit is missing, the result is fault code 3 and memory is left unchanged.
- R6: On success, `rsp_fault` is 0, `rsp_paddr` = `{leaf[31:12], va[11:0]}` and `rsp_perm` = `{leaf[5], leaf[4], leaf[3]}` (execute, write, read). On any fault, `rsp_paddr` and `rsp_perm` are 0.
- R7: An allowed access sets bit 2 of the leaf word, and a write also sets bit 1. The walker then writes the leaf once, with every other bit unchanged. When those bits are already set, it makes no write.
- R8: A memory request holds its address, direction and data until `mem_req_ready` is seen. Only one memory operation is outstanding at a time, and a write is completed by a `mem_rsp_valid` pulse.
- R9: `rsp_valid` and the result stay stable until `rsp_ready` is high. The walker is back in `ST_IDLE` (with `req_ready` = 1) in the following cycle.
- R10: `req_ready` is 1 only in `ST_IDLE`. `root_frame` is sampled at acceptance, so a new value redirects the next walk to a different table.
- R11: With memory that is always ready and answers one cycle after acceptance, `rsp_valid` rises on the Lth rising edge after the accepting edge. L is 2 for a directory fault, 6 when a write-back happens, and 4 in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_frame | input | 20 | Frame number of the current top-level directory |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_perm | output | 3 | Leaf permissions {X, W, R} (0 on fault) |
| rsp_fault | output | 2 | 0 none, 1 directory absent, 2 leaf absent, 3 protection |
| mem_req_valid | output | 1 | Memory operation requested |
| mem_req_ready | input | 1 | Memory accepts the operation |
| mem_req_write | output | 1 | 1 for a write, 0 for a read |
| mem_req_addr | output | 32 | Byte address of the table word |
| mem_req_wdata | output | 32 | Word to write |
| mem_rsp_valid | input | 1 | Read data or write acknowledge |
| mem_rsp_data | input | 32 | Read data |

## Verification
The bench memory answers on the cycle after it accepts an operation. Under that rule, a directory fault is due two rising edges after the request is taken, and a walk with no write-back is due after four. A walk that writes the leaf back is due after six. The bench computes which of these applies from its own copy of the table. It then samples `rsp_valid` on the falling edge of every cycle of the walk and requires it to be low until exactly the predicted edge has passed. In stalled-memory runs, this cycle-exact comparison is switched off and only the final result, the read addresses and the table contents are compared.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_DIR,
        ST_READ_PTE,
        ST_UPDATE_PTE,
        ST_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE        = 2'd0,
        FLT_DIR_ABSENT  = 2'd1,
        FLT_LEAF_ABSENT = 2'd2,
        FLT_PROT        = 2'd3
    } fault_e;

    // bit positions inside a table word
    localparam int ENT_V   = 0;
    localparam int ENT_D   = 1;
    localparam int ENT_REF = 2;
    localparam int ENT_PR  = 3;
    localparam int ENT_PW  = 4;
    localparam int ENT_PX  = 5;
    localparam int PERM_W  = 3;

endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10,
    parameter int ENT_LG = 2
) (
    input  logic [ADDR_W-OFF_W-1:0] frame,
    input  logic [IDX_W-1:0]        idx,
    output logic [ADDR_W-1:0]       addr
);
    localparam int PAD_W = ADDR_W - IDX_W;

    logic [ADDR_W-1:0] base_b;
    logic [ADDR_W-1:0] step_b;

    assign base_b = {frame, {OFF_W{1'b0}}};
    assign step_b = {{PAD_W{1'b0}}, idx} << ENT_LG;
    assign addr   = base_b | step_b;
endmodule

// File: rtl/pgwalk_perm.sv
module pgwalk_perm
    import pgwalk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic [ADDR_W-1:0]       entry,
    input  acc_kind_e               kind,
    output logic                    present,
    output logic                    allowed,
    output logic                    needs_update,
    output logic [ADDR_W-1:0]       updated,
    output logic [PERM_W-1:0]       perm,
    output logic [ADDR_W-OFF_W-1:0] frame
);
    logic [ADDR_W-1:0] set_mask;

    assign present = entry[ENT_V];
    assign frame   = entry[ADDR_W-1:OFF_W];

    for (genvar i = 0; i < PERM_W; i++) begin : g_perm
        assign perm[i] = entry[ENT_PR+i];
    end

    always_comb begin
        unique case (kind)
            ACC_READ:  allowed = entry[ENT_PR];
            ACC_WRITE: allowed = entry[ENT_PW];
            ACC_EXEC:  allowed = entry[ENT_PX];
            default:   allowed = 1'b0;
        endcase
    end

    always_comb begin
        set_mask          = '0;
        set_mask[ENT_REF] = 1'b1;
        set_mask[ENT_D]   = (kind == ACC_WRITE);
    end

    assign updated      = entry | set_mask;
    assign needs_update = (updated != entry);
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int DIR_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-OFF_W-1:0] root_frame,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_vaddr,
    input  logic [1:0]              req_kind,
    output logic                    rsp_valid,
    input  logic                    rsp_ready,
    output logic [ADDR_W-1:0]       rsp_paddr,
    output logic [2:0]              rsp_perm,
    output logic [1:0]              rsp_fault,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic                    mem_req_write,
    output logic [ADDR_W-1:0]       mem_req_addr,
    output logic [ADDR_W-1:0]       mem_req_wdata,
    input  logic                    mem_rsp_valid,
    input  logic [ADDR_W-1:0]       mem_rsp_data
);
    localparam int FRAME_W = ADDR_W - OFF_W;
    localparam int TBL_W   = ADDR_W - OFF_W - DIR_W;
    localparam int ENT_LG  = 2;

    walk_state_e             state_q, state_d;
    logic                    waiting_q;
    logic [ADDR_W-1:0]       va_q;
    acc_kind_e               kind_q;
    logic [FRAME_W-1:0]      root_q;
    logic [FRAME_W-1:0]      tbl_frame_q;
    logic [ADDR_W-1:0]       leaf_q;
    logic [ADDR_W-1:0]       paddr_q;
    logic [PERM_W-1:0]       perm_q;
    fault_e                  fault_q;

    logic [ADDR_W-1:0]       dir_addr;
    logic [ADDR_W-1:0]       leaf_addr;
    logic                    chk_present;
    logic                    chk_allowed;
    logic                    chk_update;
    logic [ADDR_W-1:0]       chk_entry;
    logic [PERM_W-1:0]       chk_perm;
    logic [FRAME_W-1:0]      chk_frame;
    logic                    mem_fire;
    logic                    mem_done;

    pgwalk_addr #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (DIR_W),
        .ENT_LG (ENT_LG)
    ) u_dir_addr (
        .frame (root_q),
        .idx   (va_q[ADDR_W-1 -: DIR_W]),
        .addr  (dir_addr)
    );

    pgwalk_addr #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (TBL_W),
        .ENT_LG (ENT_LG)
    ) u_leaf_addr (
        .frame (tbl_frame_q),
        .idx   (va_q[OFF_W +: TBL_W]),
        .addr  (leaf_addr)
    );

    pgwalk_perm #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) u_perm (
        .entry        (mem_rsp_data),
        .kind         (kind_q),
        .present      (chk_present),
        .allowed      (chk_allowed),
        .needs_update (chk_update),
        .updated      (chk_entry),
        .perm         (chk_perm),
        .frame        (chk_frame)
    );

    assign mem_fire = mem_req_valid && mem_req_ready;
    assign mem_done = waiting_q && mem_rsp_valid;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_READ_DIR;
            end
            ST_READ_DIR: begin
                if (mem_done) state_d = mem_rsp_data[ENT_V] ? ST_READ_PTE : ST_DONE;
            end
            ST_READ_PTE: begin
                if (mem_done) begin
                    if (chk_present && chk_allowed && chk_update) state_d = ST_UPDATE_PTE;
                    else                                          state_d = ST_DONE;
                end
            end
            ST_UPDATE_PTE: begin
                if (mem_done) state_d = ST_DONE;
            end
            ST_DONE: begin
                if (rsp_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and walk registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            waiting_q   <= 1'b0;
            va_q        <= '0;
            kind_q      <= ACC_READ;
            root_q      <= '0;
            tbl_frame_q <= '0;
            leaf_q      <= '0;
            paddr_q     <= '0;
            perm_q      <= '0;
            fault_q     <= FLT_NONE;
        end else begin
            state_q <= state_d;
            if (mem_fire)      waiting_q <= 1'b1;
            else if (mem_done) waiting_q <= 1'b0;

            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_vaddr;
                        kind_q <= acc_kind_e'(req_kind);
                        root_q <= root_frame;
                    end
                end
                ST_READ_DIR: begin
                    if (mem_done) begin
                        tbl_frame_q <= mem_rsp_data[ADDR_W-1:OFF_W];
                        if (!mem_rsp_data[ENT_V]) begin
                            fault_q <= FLT_DIR_ABSENT;
                            paddr_q <= '0;
                            perm_q  <= '0;
                        end
                    end
                end
                ST_READ_PTE: begin
                    if (mem_done) begin
                        leaf_q <= chk_entry;
                        if (!chk_present) begin
                            fault_q <= FLT_LEAF_ABSENT;
                            paddr_q <= '0;
                            perm_q  <= '0;
                        end else if (!chk_allowed) begin
                            fault_q <= FLT_PROT;
                            paddr_q <= '0;
                            perm_q  <= '0;
                        end else begin
                            fault_q <= FLT_NONE;
                            paddr_q <= {chk_frame, va_q[OFF_W-1:0]};
                            perm_q  <= chk_perm;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready     = 1'b0;
        rsp_valid     = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = leaf_addr;
        mem_req_wdata = '0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_READ_DIR: begin
                mem_req_valid = !waiting_q;
                mem_req_addr  = dir_addr;
            end
            ST_READ_PTE: begin
                mem_req_valid = !waiting_q;
            end
            ST_UPDATE_PTE: begin
                mem_req_valid = !waiting_q;
                mem_req_write = 1'b1;
                mem_req_wdata = leaf_q;
            end
            ST_DONE: rsp_valid = 1'b1;
            default: ;
        endcase
    end

    assign rsp_paddr = paddr_q;
    assign rsp_perm  = perm_q;
    assign rsp_fault = fault_q;
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_vaddr,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic [2:0]        rsp_perm,
    input logic [1:0]        rsp_fault,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [ADDR_W-1:0] mem_req_wdata
);
    logic [OFF_W-1:0] off_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                      off_q <= '0;
        else if (req_valid && req_ready) off_q <= req_vaddr[OFF_W-1:0];
    end

    // R10: while accepting requests nothing else is active
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!rsp_valid && !mem_req_valid));

    // R9: answer held until taken
    a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
                                       && $stable(rsp_perm) && $stable(rsp_fault)));

    // R8: memory request stable while stalled
    a_r8_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
                                               && $stable(mem_req_write) && $stable(mem_req_wdata)));

    // R6: faults carry zero address and permissions
    a_r6_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0 && rsp_perm == 3'd0));

    // R6: offset passes through untouched
    a_r6_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'd0) |-> (rsp_paddr[OFF_W-1:0] == off_q));

    // R7: a written leaf is present and marked referenced
    a_r7_wb_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> (mem_req_wdata[0] && mem_req_wdata[2]));
endmodule

bind pgwalk_top pgwalk_chk #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_paddr     (rsp_paddr),
    .rsp_perm      (rsp_perm),
    .rsp_fault     (rsp_fault),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata)
);

// File: tb/pgwalk_top_tb.sv
module pgwalk_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] root_frame = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_perm;
    logic [1:0]  rsp_fault;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int n_checks = 0;
    int n_err    = 0;

    always #2 clk = ~clk;

    pgwalk_top u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .root_frame    (root_frame),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_kind      (req_kind),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_paddr     (rsp_paddr),
        .rsp_perm      (rsp_perm),
        .rsp_fault     (rsp_fault),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    // memory seen by the walker, and the bench's own prediction of it
    logic [31:0] dut_mem [logic [31:0]];
    logic [31:0] ref_mem [logic [31:0]];

    function automatic logic [31:0] dut_rd(input logic [31:0] a);
        return dut_mem.exists(a) ? dut_mem[a] : 32'h0;
    endfunction

    function automatic logic [31:0] ref_rd(input logic [31:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : 32'h0;
    endfunction

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        dut_mem[a] = d;
        ref_mem[a] = d;
    endtask

    function automatic logic [31:0] ent(input logic [19:0] fr, input bit v, input bit d,
                                        input bit r, input bit pr, input bit pw, input bit px);
        return {fr, 6'h0, px, pw, pr, r, d, v};
    endfunction

    // memory responder: answers one cycle after accepting
    bit          stall_mode = 0;
    int          stall_cnt  = 0;
    bit          due        = 0;
    logic [31:0] due_addr;
    logic        due_wr;
    logic [31:0] due_wdata;
    int          wr_count = 0;
    int          rd_count = 0;
    logic [31:0] rd_log [4];

    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (!rst_n) begin
            due = 0;
        end else if (due) begin
            if (due_wr) begin
                dut_mem[due_addr] = due_wdata;
                wr_count++;
                mem_rsp_data = 32'h0;
            end else begin
                mem_rsp_data = dut_rd(due_addr);
                if (rd_count < 4) rd_log[rd_count] = due_addr;
                rd_count++;
            end
            mem_rsp_valid = 1'b1;
            due = 0;
        end
        stall_cnt++;
        mem_req_ready = stall_mode ? (stall_cnt % 3 == 0) : 1'b1;
        if (rst_n && !due && !mem_rsp_valid && mem_req_valid && mem_req_ready) begin
            due       = 1;
            due_addr  = mem_req_addr;
            due_wr    = mem_req_write;
            due_wdata = mem_req_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one translation, predicted from the requirements and compared
    task automatic walk(input logic [31:0] va, input logic [1:0] kind, input bit hold);
        logic [31:0] daddr, laddr, de, le, nw, e_pa;
        logic [1:0]  e_f;
        logic [2:0]  e_pm;
        bit          ok, e_wr;
        int          e_lat, e_rd, k, wr0;

        // R2 addresses, R3/R4/R5 faults, R6 result, R7 update, R11 latency
        daddr = {root_frame, 12'h0} | {20'h0, va[31:22], 2'b00};
        de    = ref_rd(daddr);
        laddr = {de[31:12], 12'h0} | {18'h0, va[21:12], 2'b00};
        le    = 32'h0;
        e_wr  = 0; e_pa = 0; e_pm = 0; nw = 0;
        if (!de[0]) begin
            e_f = 2'd1; e_lat = 2; e_rd = 1;
        end else begin
            le = ref_rd(laddr); e_rd = 2; e_lat = 4;
            if (!le[0]) e_f = 2'd2;
            else begin
                ok = (kind == 2'd0) ? le[3] : (kind == 2'd1) ? le[4] :
                     (kind == 2'd2) ? le[5] : 1'b0;
                if (!ok) e_f = 2'd3;
                else begin
                    e_f  = 2'd0;
                    e_pa = {le[31:12], va[11:0]};
                    e_pm = le[5:3];
                    nw   = le | 32'h4 | ((kind == 2'd1) ? 32'h2 : 32'h0);
                    if (nw != le) begin
                        e_wr = 1; e_lat = 6; ref_mem[laddr] = nw;
                    end
                end
            end
        end

        wr0 = wr_count;
        rd_count = 0;
        @(negedge clk);
        check(req_ready === 1'b1, "R10", "req_ready before request", {31'h0, req_ready}, 32'h1);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind;
        @(negedge clk);
        req_valid = 1'b0;
        k = 1;
        forever begin
            if (!stall_mode)
                check(rsp_valid === (k >= e_lat + 1), "R11", "rsp_valid timing",
                      {31'h0, rsp_valid}, {31'h0, (k >= e_lat + 1)});
            if (rsp_valid) break;
            check(req_ready === 1'b0, "R10", "req_ready during walk", {31'h0, req_ready}, 32'h0);
            if (k > 3000) begin
                check(0, "R11", "walk never finished", 32'h0, 32'h1);
                break;
            end
            @(negedge clk);
            k++;
        end

        check(rsp_fault === e_f, (e_f == 2'd1) ? "R3" : (e_f == 2'd2) ? "R4" : "R5",
              "fault code", {30'h0, rsp_fault}, {30'h0, e_f});
        check(rsp_paddr === e_pa, "R6", "paddr", rsp_paddr, e_pa);
        check(rsp_perm === e_pm, "R6", "perm", {29'h0, rsp_perm}, {29'h0, e_pm});
        check(rd_count == e_rd, "R2", "read count", rd_count, e_rd);
        check(rd_log[0] === daddr, "R2", "directory address", rd_log[0], daddr);
        if (e_rd == 2) check(rd_log[1] === laddr, "R2", "leaf address", rd_log[1], laddr);
        check((wr_count - wr0) == (e_wr ? 1 : 0), "R7", "write-back count",
              wr_count - wr0, e_wr ? 1 : 0);
        if (de[0]) check(dut_rd(laddr) === ref_rd(laddr), "R7", "leaf word after walk",
                         dut_rd(laddr), ref_rd(laddr));
        if (e_f != 2'd0) check(dut_rd(laddr) === le || !de[0], "R5", "table unmodified on fault",
                               dut_rd(laddr), le);

        if (hold) begin
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                check(rsp_valid === 1'b1 && rsp_paddr === e_pa && rsp_fault === e_f,
                      "R9", "result held", rsp_paddr, e_pa);
            end
            rsp_ready = 1'b1;
        end
        @(negedge clk);
        check(rsp_valid === 1'b0 && req_ready === 1'b1, "R9", "idle after take",
              {30'h0, rsp_valid, req_ready}, 32'h1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        check(0, "R11", "watchdog expired", 32'h0, 32'h1);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin : stim
        // root A directory at frame 0x00010, root B at frame 0x00020
        poke(32'h0001_0004, ent(20'h00100, 1, 0, 0, 0, 0, 0));
        poke(32'h0001_0FFC, ent(20'h00200, 1, 0, 0, 0, 0, 0));
        poke(32'h0010_000C, ent(20'h12345, 1, 0, 0, 1, 1, 0));
        poke(32'h0010_0010, ent(20'h0ABCD, 1, 0, 0, 1, 0, 1));
        poke(32'h0010_0014, ent(20'h00777, 1, 0, 1, 1, 0, 0));
        poke(32'h0010_001C, ent(20'h0BEEF, 1, 0, 0, 1, 1, 0));
        poke(32'h0020_0FFC, ent(20'hFFFFF, 1, 1, 1, 1, 1, 1));
        poke(32'h0002_0004, ent(20'h00300, 1, 0, 0, 0, 0, 0));
        poke(32'h0030_000C, ent(20'h55555, 1, 0, 0, 1, 0, 0));

        repeat (3) @(negedge clk);
        check(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req_valid === 1'b0,
              "R1", "state in reset", {29'h0, req_ready, rsp_valid, mem_req_valid}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req_valid === 1'b0,
              "R1", "state after reset", {29'h0, req_ready, rsp_valid, mem_req_valid}, 32'h4);

        root_frame = 20'h00010;
        walk(32'h0040_3ABC, 2'd0, 0);   // R7 read sets referenced bit
        walk(32'h0040_3ABC, 2'd0, 0);   // R7 no write when already set
        walk(32'h0040_3ABC, 2'd1, 0);   // R7 write sets dirty
        walk(32'h0040_3ABC, 2'd1, 0);
        walk(32'h0040_4010, 2'd2, 0);   // execute allowed
        walk(32'h0040_4010, 2'd2, 0);
        walk(32'h0040_5000, 2'd2, 0);   // R5 execute without X
        walk(32'h0040_5000, 2'd1, 0);   // R5 write without W
        walk(32'h0040_5000, 2'd0, 0);
        walk(32'h0040_3ABC, 2'd3, 0);   // R5 reserved kind
        walk(32'h0080_0000, 2'd0, 0);   // R3 absent directory word
        walk(32'h0000_0000, 2'd0, 0);   // R3 index 0
        walk(32'h0040_6000, 2'd0, 0);   // R4 absent leaf
        walk(32'hFFFF_FFFF, 2'd1, 0);   // R2 top indices, full offset
        root_frame = 20'h00020;         // R10 different table
        walk(32'h0040_3ABC, 2'd0, 0);
        root_frame = 20'h00010;
        rsp_ready = 1'b0;
        walk(32'h0040_3ABC, 2'd0, 1);   // R9 hold
        stall_mode = 1;                 // R8 stalled memory
        walk(32'h0040_7123, 2'd1, 0);
        walk(32'h0040_4010, 2'd0, 0);
        walk(32'h0080_0000, 2'd2, 0);
        stall_mode = 0;
        repeat (2) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule